// File: doc/BRIEF.md
# Four-Bit Universal Shift Register

This block is a small register that can hold its value, shift its contents one place in either direction, or take a whole new word in parallel. A two-bit function select picks one of these four actions on every rising clock edge. A synchronous clear input forces the stored word to zero and overrides the select. Both ends of the register have a serial input and a serial output, so the register can be used as a serial-to-parallel converter, a parallel-to-serial converter, or a plain holding register.

Bit 3 is the leftmost bit. A right shift moves every bit one place toward bit 0. The vacated bit 3 is filled from the serial input that serves right shifts. A left shift moves every bit toward bit 3. The vacated bit 0 is filled from the serial input that serves left shifts. The parallel output always shows the stored word. The two serial outputs show the bits that sit at each end and would leave on the next shift.

Top module: `ushift4`

## Requirements
- R1: When `clr` is 1 at a rising edge, the stored word becomes 0000 after that edge, whatever the value of `{sel0,sel1}`.
- R2: With `clr`=0 and `{sel0,sel1}`=00, the stored word does not change across the edge.
- R3: With `clr`=0 and `{sel0,sel1}`=01, the stored word becomes `{sin_rshift, q[3:1]}`. This is a right shift, and `sin_rshift` enters bit 3.
- R4: With `clr`=0 and `{sel0,sel1}`=10, the stored word becomes `{q[2:0], sin_lshift}`. This is a left shift, and `sin_lshift` enters bit 0.
- R5: With `clr`=0 and `{sel0,sel1}`=11, the stored word becomes `par_in`.
- R6: `msb_out` always equals bit 3 and `lsb_out` always equals bit 0 of the stored word shown on `par_out`.
- R7: Input changes between rising edges have no effect on `par_out`. The word changes only at a rising clock edge.
- R8: Four consecutive right shifts replace the whole word with the last four serial bits, and the oldest of them ends in bit 0. The old word leaves in order on `lsb_out`, one bit per edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| clr | input | 1 | Synchronous clear, highest priority |
| sel0 | input | 1 | Function select, first bit |
| sel1 | input | 1 | Function select, second bit |
| par_in | input | 4 | Parallel load data |
| sin_rshift | input | 1 | Serial bit taken into bit 3 on a right shift |
| sin_lshift | input | 1 | Serial bit taken into bit 0 on a left shift |
| par_out | output | 4 | Stored word |
| msb_out | output | 1 | Bit 3 of the stored word |
| lsb_out | output | 1 | Bit 0 of the stored word |

## Verification
The stored word reaches `par_out` with no logic in between. Any wrong update, such as a misrouted serial bit, a swapped select code or a clear that loses to a load, shows on the ports one clock edge after the bad update. A wrong serial output shows on `msb_out` or `lsb_out` in the same cycle as the stored word. The tests therefore compare every port right after each edge. They also run long shift chains, so that a bit dropped or duplicated in the middle of the word shows up when it reaches an end.

// File: rtl/ushift4.sv
module ushift4 #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             sel0,
  input  logic             sel1,
  input  logic [WIDTH-1:0] par_in,
  input  logic             sin_rshift,
  input  logic             sin_lshift,
  output logic [WIDTH-1:0] par_out,
  output logic             msb_out,
  output logic             lsb_out
);

  localparam int MSB = WIDTH - 1;

  logic [MSB:0] q;
  logic [MSB:0] q_nxt;

  always_comb begin
    unique case ({sel0, sel1})
      2'b00: q_nxt = q;
      2'b01: q_nxt = {sin_rshift, q[MSB:1]};
      2'b10: q_nxt = {q[MSB-1:0], sin_lshift};
      default: q_nxt = par_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) q <= '0;
    else     q <= q_nxt;
  end

  assign par_out = q;
  assign msb_out = q[MSB];
  assign lsb_out = q[0];

endmodule

// File: rtl/ushift4_chk.sv
module ushift4_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr,
  input logic             sel0,
  input logic             sel1,
  input logic [WIDTH-1:0] par_in,
  input logic             sin_rshift,
  input logic             sin_lshift,
  input logic [WIDTH-1:0] par_out,
  input logic             msb_out,
  input logic             lsb_out
);

  logic armed = 1'b0;
  always_ff @(posedge clk) if (clr) armed <= 1'b1;

  // R1
  clr_zero_chk: assert property (@(posedge clk) disable iff (!armed)
    clr |=> (par_out == '0));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !sel0 && !sel1) |=> $stable(par_out));

  // R3
  rshift_chk: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !sel0 && sel1) |=>
      (par_out == {$past(sin_rshift), $past(par_out[WIDTH-1:1])}));

  // R4
  lshift_chk: assert property (@(posedge clk) disable iff (!armed)
    (!clr && sel0 && !sel1) |=>
      (par_out == {$past(par_out[WIDTH-2:0]), $past(sin_lshift)}));

  // R5
  load_chk: assert property (@(posedge clk) disable iff (!armed)
    (!clr && sel0 && sel1) |=> (par_out == $past(par_in)));

  // R6
  ends_chk: assert property (@(posedge clk) disable iff (!armed)
    (msb_out == par_out[WIDTH-1]) && (lsb_out == par_out[0]));

endmodule

bind ushift4 ushift4_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_ushift4.sv
module sim_ushift4;
  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       sel0 = 1'b0, sel1 = 1'b0;
  logic [3:0] par_in = 4'h0;
  logic       sin_rshift = 1'b0, sin_lshift = 1'b0;
  logic [3:0] par_out;
  logic       msb_out, lsb_out;
  int checks = 0, errors = 0;
  logic [3:0] exp_q;

  always #5 clk = ~clk;

  ushift4 u0 (.clk, .clr, .sel0, .sel1, .par_in, .sin_rshift, .sin_lshift,
              .par_out, .msb_out, .lsb_out);

  task automatic chk(string req, logic [3:0] exp);
    checks++;
    if (par_out !== exp) begin
      errors++;
      $display("FAIL %s par_out actual=%b expected=%b", req, par_out, exp);
    end
    checks++;
    if (msb_out !== exp[3] || lsb_out !== exp[0]) begin
      errors++;
      $display("FAIL R6 (%s) msb/lsb actual=%b%b expected=%b%b",
               req, msb_out, lsb_out, exp[3], exp[0]);
    end
  endtask

  task automatic step(logic c, logic s0, logic s1, logic [3:0] d, logic sr, logic sl);
    @(negedge clk);
    clr = c; sel0 = s0; sel1 = s1; par_in = d; sin_rshift = sr; sin_lshift = sl;
    @(posedge clk);
    #1;
  endtask

  task automatic t_load;
    step(0, 1, 1, 4'b1011, 0, 0); exp_q = 4'b1011; chk("R5", exp_q);
    step(0, 1, 1, 4'b0110, 1, 1); exp_q = 4'b0110; chk("R5", exp_q);
  endtask

  task automatic t_hold;
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 0, ~exp_q, i[0], ~i[0]);
      chk("R2", exp_q);
    end
  endtask

  task automatic t_right;
    step(0, 1, 1, 4'b1001, 0, 0); exp_q = 4'b1001;
    step(0, 0, 1, 4'hF, 1, 0); exp_q = {1'b1, exp_q[3:1]}; chk("R3", exp_q);
    step(0, 0, 1, 4'h0, 0, 1); exp_q = {1'b0, exp_q[3:1]}; chk("R3", exp_q);
  endtask

  task automatic t_left;
    step(0, 1, 1, 4'b1001, 0, 0); exp_q = 4'b1001;
    step(0, 1, 0, 4'h0, 0, 1); exp_q = {exp_q[2:0], 1'b1}; chk("R4", exp_q);
    step(0, 1, 0, 4'hF, 1, 0); exp_q = {exp_q[2:0], 1'b0}; chk("R4", exp_q);
  endtask

  task automatic t_clear;
    for (int c = 0; c < 4; c++) begin
      step(0, 1, 1, 4'b1111, 0, 0);
      step(1, c[1], c[0], 4'b1111, 1, 1); exp_q = 4'b0000; chk("R1", exp_q);
    end
  endtask

  task automatic t_serial;
    logic [3:0] old_w, bits;
    old_w = 4'b1101; bits = 4'b0110;
    step(0, 1, 1, old_w, 0, 0);
    for (int i = 0; i < 4; i++) begin
      checks++;
      if (lsb_out !== old_w[i]) begin
        errors++;
        $display("FAIL R8 lsb_out step %0d actual=%b expected=%b", i, lsb_out, old_w[i]);
      end
      step(0, 0, 1, 4'h0, bits[i], 0);
    end
    chk("R8", {bits[3], bits[2], bits[1], bits[0]});
  endtask

  task automatic t_edge;
    step(0, 1, 1, 4'b0101, 0, 0); exp_q = 4'b0101;
    @(negedge clk);
    clr = 1; sel0 = 1; sel1 = 1; par_in = 4'b1010; sin_rshift = 1; sin_lshift = 1;
    #2; chk("R7", exp_q);
    sel0 = 0; sel1 = 1;
    #1; chk("R7", exp_q);
    clr = 0; sel0 = 0; sel1 = 0;
    @(posedge clk); #1; chk("R7", exp_q);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    exp_q = 4'b0000; chk("R1", exp_q);
    t_load;
    t_hold;
    t_right;
    t_left;
    t_clear;
    t_serial;
    t_edge;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule